// File: doc/BRIEF.md
# Three-Source Interrupt Vector Arbiter

This block merges the interrupt requests of three serial sub-units into one prioritised request for the CPU. The sub-units are two asynchronous serial channels, A and B, and one SPI unit. Each source has a programmable 3-bit level. The block presents on `irq_level` the highest level among the sources that are both requesting and enabled. When the CPU acknowledges that level, the block returns an 8-bit vector number.

The upper six vector bits come from one shared register written by software. The lower two bits are filled in by hardware from the winning source. The three vectors therefore sit next to each other in the vector table. A level of 0 disables a source. When two or more sources share the same level, a fixed tie order decides: SPI first, then channel A, then channel B.

Top module: `irq_vec_arbiter`

## Requirements
- R1: After reset, the vector register reads 0x0F (address 0) and all three level registers read 0 (addresses 1, 2 and 3).
- R2: A write to address 0 stores only data bits [7:2]. A read of address 0 always returns the stored bits [7:2] with bits [1:0] equal to 11.
- R3: Addresses 1, 2 and 3 hold the 3-bit levels of channel A, channel B and SPI. A write stores data bits [2:0]. A read returns the level zero-extended to 8 bits. A level changes only when its own address is written.
- R4: A source whose level is 0 is never recognised, even while it requests. With no recognised source, `irq_level` is 0.
- R5: One cycle after the inputs settle, `irq_level` equals the highest level among the sources that request with a nonzero level.
- R6: Among requesting sources with the same highest level, SPI wins over channel A, and channel A wins over channel B.
- R7: An acknowledge (`ack_valid` high) whose `ack_level` equals the current nonzero winning level produces, on the next cycle, `ack_hit`=1 and `ack_vector` = {register bits [7:2], code}. The code is 00 for channel A, 01 for channel B and 10 for SPI.
- R8: An acknowledge whose level differs from the current winning level, or that arrives while no source is recognised, produces on the next cycle `ack_miss`=1, `ack_hit`=0 and `ack_vector`=0.
- R9: `ack_hit` and `ack_miss` are never high together. Both are low on the cycle after a cycle without `ack_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 3 | Request lines: bit 0 channel A, bit 1 channel B, bit 2 SPI |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 vector, 1 level A, 2 level B, 3 level SPI |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| ack_valid | input | 1 | CPU acknowledge cycle |
| ack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Registered request level to the CPU, 0 for none |
| ack_hit | output | 1 | Block answers the acknowledge with a vector |
| ack_miss | output | 1 | Block does not answer the acknowledge |
| ack_vector | output | 8 | Vector returned on a hit, 0 otherwise |

## Verification
The assertions assume that `ack_valid` is only a one-cycle sample of the request state. They make no assumption on how `src_req` relates to earlier acknowledges, because the block keeps no record of past grants. The bench keeps `src_req` and the level registers stable from the cycle `irq_level` is sampled until the acknowledge response has been checked. Expected values therefore come from one settled input state. The random acknowledge levels are drawn half from the expected winning level and half from the full 3-bit range, so both hits and misses, including acknowledges at level 0, occur often.

// File: rtl/irq_arb_pkg.sv
// Shared types and register addresses for the three-source vector arbiter.
package irq_arb_pkg;
    localparam int NSRC = 3;

    // Low vector bits supplied by hardware for each source; also the index
    // of the source in the per-source arrays.
    typedef enum logic [1:0] {
        SRC_A   = 2'b00,
        SRC_B   = 2'b01,
        SRC_SPI = 2'b10
    } src_code_t;

    localparam logic [1:0] ADDR_VEC     = 2'd0;
    localparam logic [1:0] ADDR_LVL_A   = 2'd1;
    localparam logic [1:0] ADDR_LVL_B   = 2'd2;
    localparam logic [1:0] ADDR_LVL_SPI = 2'd3;
endpackage

// File: rtl/irq_cfg_regs.sv
// Configuration registers: shared vector base (bits above the two source
// bits) and one level register per source, with a combinational read mux.
// Assumes one write per cycle; reset is synchronous and active low.
module irq_cfg_regs
    import irq_arb_pkg::*;
#(
    parameter int           VEC_W   = 8,
    parameter int           LVL_W   = 3,
    parameter logic [7:0]   RST_VEC = 8'h0F
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [1:0]                    reg_addr,
    input  logic [VEC_W-1:0]              reg_wdata,
    output logic [VEC_W-1:0]              reg_rdata,
    output logic [VEC_W-3:0]              vec_base,
    output logic [NSRC-1:0][LVL_W-1:0]    lvl
);
    localparam int BASE_W = VEC_W - 2;

    // Register updates from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_base <= RST_VEC[VEC_W-1:2];
            lvl      <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_VEC:     vec_base     <= reg_wdata[VEC_W-1:2];
                ADDR_LVL_A:   lvl[SRC_A]   <= reg_wdata[LVL_W-1:0];
                ADDR_LVL_B:   lvl[SRC_B]   <= reg_wdata[LVL_W-1:0];
                default:      lvl[SRC_SPI] <= reg_wdata[LVL_W-1:0];
            endcase
        end
    end

    // Read mux; low vector bits read back as ones.
    always_comb begin
        case (reg_addr)
            ADDR_VEC:   reg_rdata = {vec_base, 2'b11};
            ADDR_LVL_A: reg_rdata = {{(VEC_W-LVL_W){1'b0}}, lvl[SRC_A]};
            ADDR_LVL_B: reg_rdata = {{(VEC_W-LVL_W){1'b0}}, lvl[SRC_B]};
            default:    reg_rdata = {{(VEC_W-LVL_W){1'b0}}, lvl[SRC_SPI]};
        endcase
    end

    AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(lvl)); // R3
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr || reg_addr != ADDR_VEC) |=> $stable(vec_base)); // R2

    logic [BASE_W-1:0] unused_base_w;
    assign unused_base_w = '0;
endmodule

// File: rtl/irq_prio_pick.sv
// Priority picker: masks each request with its level, then selects the
// highest level, breaking ties in the fixed order SPI, A, B.
// Purely combinational; clk/rst_n only clock the assertions.
module irq_prio_pick
    import irq_arb_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSRC-1:0]               req,
    input  logic [NSRC-1:0][LVL_W-1:0]    lvl,
    output logic [LVL_W-1:0]              win_level,
    output src_code_t                     win_src
);
    logic [NSRC-1:0][LVL_W-1:0] eff;

    for (genvar g = 0; g < NSRC; g++) begin : g_eff
        // Effective level: zero unless the source is requesting.
        assign eff[g] = req[g] ? lvl[g] : '0;

        AST_WIN_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            win_level >= eff[g]); // R5
    end

    // Scan in tie order (SPI, A, B); strict compare keeps the earlier one.
    always_comb begin
        win_level = '0;
        win_src   = SRC_A;
        for (int k = 0; k < NSRC; k++) begin
            automatic int s = (k == 0) ? (NSRC - 1) : (k - 1);
            if (eff[s] > win_level) begin
                win_level = eff[s];
                win_src   = src_code_t'(s[1:0]);
            end
        end
    end

    AST_WIN_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_level != '0) |-> req[win_src]); // R4
    AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (win_level != '0) |-> (lvl[win_src] == win_level)); // R4
endmodule

// File: rtl/irq_ack_resp.sv
// Output stage: registers the request level and answers acknowledges with
// the vector when the acknowledged level equals the current winner.
// Assumes ack_valid is a single-cycle sample; responses appear one cycle later.
module irq_ack_resp
    import irq_arb_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int LVL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ack_valid,
    input  logic [LVL_W-1:0]     ack_level,
    input  logic [LVL_W-1:0]     win_level,
    input  src_code_t            win_src,
    input  logic [VEC_W-3:0]     vec_base,
    output logic [LVL_W-1:0]     irq_level,
    output logic                 ack_hit,
    output logic                 ack_miss,
    output logic [VEC_W-1:0]     ack_vector
);
    logic match;
    assign match = (win_level != '0) && (ack_level == win_level);

    // Register the request level and the acknowledge response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level  <= '0;
            ack_hit    <= 1'b0;
            ack_miss   <= 1'b0;
            ack_vector <= '0;
        end else begin
            irq_level  <= win_level;
            ack_hit    <= ack_valid && match;
            ack_miss   <= ack_valid && !match;
            ack_vector <= (ack_valid && match) ? {vec_base, win_src} : '0;
        end
    end

    AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_hit && ack_miss)); // R9
    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid |=> (!ack_hit && !ack_miss)); // R9
    AST_HIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |-> (ack_vector[1:0] != 2'b11)); // R7
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ack_miss |-> (ack_vector == '0)); // R8
endmodule

// File: rtl/irq_vec_arbiter.sv
// Top: three-source interrupt vector arbiter. Connects the configuration
// registers, the priority picker and the acknowledge stage.
// Source index/code: 0 channel A, 1 channel B, 2 SPI.
module irq_vec_arbiter
    import irq_arb_pkg::*;
#(
    parameter int         VEC_W   = 8,
    parameter int         LVL_W   = 3,
    parameter logic [7:0] RST_VEC = 8'h0F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         src_req,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [VEC_W-1:0]   reg_wdata,
    output logic [VEC_W-1:0]   reg_rdata,
    input  logic               ack_valid,
    input  logic [LVL_W-1:0]   ack_level,
    output logic [LVL_W-1:0]   irq_level,
    output logic               ack_hit,
    output logic               ack_miss,
    output logic [VEC_W-1:0]   ack_vector
);
    logic [VEC_W-3:0]             vec_base;
    logic [NSRC-1:0][LVL_W-1:0]   lvl;
    logic [LVL_W-1:0]             win_level;
    src_code_t                    win_src;

    irq_cfg_regs #(.VEC_W(VEC_W), .LVL_W(LVL_W), .RST_VEC(RST_VEC)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vec_base(vec_base), .lvl(lvl)
    );

    irq_prio_pick #(.LVL_W(LVL_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(src_req), .lvl(lvl),
        .win_level(win_level), .win_src(win_src)
    );

    irq_ack_resp #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_level(ack_level),
        .win_level(win_level), .win_src(win_src), .vec_base(vec_base),
        .irq_level(irq_level), .ack_hit(ack_hit), .ack_miss(ack_miss),
        .ack_vector(ack_vector)
    );
endmodule

// File: tb/sim_irq_vec_arbiter.sv
// Bench: directed corners plus seeded random configurations and requests.
module sim_irq_vec_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_req = '0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_level = '0;
    logic [2:0] irq_level;
    logic       ack_hit, ack_miss;
    logic [7:0] ack_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench copy of the configuration, kept from its own writes.
    logic [5:0] m_base = 6'h03;
    logic [2:0] m_lvl [3];

    always #10 clk = ~clk;

    irq_vec_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack_valid(ack_valid), .ack_level(ack_level), .irq_level(irq_level),
        .ack_hit(ack_hit), .ack_miss(ack_miss), .ack_vector(ack_vector)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected winner: order SPI, A, B with strict greater-than.
    function automatic void model(input logic [2:0] req, output logic [2:0] lv,
                                  output logic [1:0] code);
        int order [3] = '{2, 0, 1};
        lv = 0; code = 0;
        foreach (order[k]) begin
            if (req[order[k]] && m_lvl[order[k]] > lv) begin
                lv = m_lvl[order[k]];
                code = 2'(order[k]);
            end
        end
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 0) m_base = d[7:2];
        else m_lvl[a-1] = d[2:0];
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    // Apply requests, check level, acknowledge at alevel, check response.
    task automatic run(input logic [2:0] req, input logic [2:0] alevel, input string tag);
        logic [2:0] lv;
        logic [1:0] code;
        bit hit;
        @(negedge clk);
        src_req = req;
        model(req, lv, code);
        @(negedge clk);
        chk(irq_level == lv, {tag, " R5 irq_level"}, irq_level, lv);
        ack_valid = 1'b1; ack_level = alevel;
        @(negedge clk);
        ack_valid = 1'b0;
        hit = (lv != 0) && (alevel == lv);
        if (hit) begin
            chk(ack_hit && !ack_miss, {tag, " R7 hit"}, {ack_hit, ack_miss}, 2);
            chk(ack_vector == {m_base, code}, {tag, " R7 vector"}, ack_vector, {m_base, code});
        end else begin
            chk(ack_miss && !ack_hit, {tag, " R8 miss"}, {ack_hit, ack_miss}, 1);
            chk(ack_vector == 0, {tag, " R8 vector"}, ack_vector, 0);
        end
        @(negedge clk);
        chk(!ack_hit && !ack_miss, {tag, " R9 idle"}, {ack_hit, ack_miss}, 0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1F2E3D4C);
        foreach (m_lvl[i]) m_lvl[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(0, 8'h0F, "R1 vector reset");
        rd(1, 8'h00, "R1 level A reset");
        rd(2, 8'h00, "R1 level B reset");
        rd(3, 8'h00, "R1 level SPI reset");
        // R4 all disabled: requests ignored, ack at 0 misses
        run(3'b111, 3'd0, "R4 disabled");
        // R2 low bits ignored on write, read as 11
        wr(0, 8'h50);
        rd(0, 8'h53, "R2 vector low bits");
        wr(0, 8'hA6);
        rd(0, 8'hA7, "R2 vector rewrite");
        // R3 level readback and isolation
        wr(1, 8'hFD);
        rd(1, 8'h05, "R3 level A");
        rd(2, 8'h00, "R3 level B untouched");
        wr(2, 8'h05); wr(3, 8'h05);
        // R6 ties
        run(3'b111, 3'd5, "R6 tie all");
        run(3'b011, 3'd5, "R6 tie A over B");
        run(3'b010, 3'd5, "R7 B alone");
        run(3'b111, 3'd4, "R8 wrong level");
        wr(3, 8'h00);
        run(3'b100, 3'd0, "R4 SPI level 0");
        wr(2, 8'h07);
        run(3'b011, 3'd7, "R5 B higher");
        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [2:0] lv;
            logic [1:0] code;
            logic [2:0] req, al;
            if ($urandom_range(3) == 0) wr(2'($urandom_range(3)), 8'($urandom));
            req = 3'($urandom);
            model(req, lv, code);
            al = ($urandom_range(1) == 0) ? lv : 3'($urandom);
            run(req, al, "rand");
        end
        rd(0, {m_base, 2'b11}, "R2 final vector");
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule